// File: doc/BRIEF.md
# Pen-Down Rate-Limited Scan Trigger Controller

This block sits between the pen-down interrupt of a resistive touch-screen ADC and the engine that runs a conversion scan. It turns each pen-down event into a single-cycle scan trigger. After that it keeps issuing triggers at a programmed rate, so that a pen resting on the panel is sampled steadily rather than on every edge of the raw interrupt. The interrupt is derived from the same analog line the ADC switches while it converts, so the controller masks its own interrupt source while scans are in flight. It opens the mask only in windows where a fresh edge means real pen activity.

Each scan ends with a done strobe. The controller then arms a one-shot tick counter with the programmed scan interval minus the scan duration, so triggers land on the interval grid. Once the pen lifts, the controller keeps polling for a fixed number of extra intervals and then parks in a standby state with the interrupt open, waiting for the next touch. Dropping the enable input shuts everything down and masks the interrupt.

Top module: `pen_trig_ctrl`

## Requirements
- R1: After reset the controller is in the off state with the interrupt mask set, no trigger and no error. State codes on `state_o` are: 0 off, 1 standby, 2 polling with interrupt masked, 3 polling with interrupt open, 4 waiting after a trigger.
- R2: A rising `enable_i` in the off state moves to standby (code 1) and clears the mask on the next clock. A falling `enable_i` in any state returns to off (code 0) with the mask set, stops the timer, and no further trigger follows.
- R3: A rising edge of `pen_irq_i` seen while unmasked and not off produces one trigger pulse three clocks after the input changes. The same event sets the mask, enters code 4, clears the poll count and cancels the timer. An edge in the off state does nothing.
- R4: On timer expiry in code 4 with fewer than six completed polls, the poll count increments and the timer restarts with the full interval. After six polls, expiry moves to standby (code 1) unmasked without a trigger. A single touch therefore yields seven triggers spaced two intervals apart.
- R5: When the incremented poll count reaches three or more, the state is code 3 with the mask clear. Its expiry sets the mask, triggers and enters code 4. A pen edge inside that window restarts the whole series from a count of zero.
- R6: A pen edge arriving while the mask is set is dropped and never produces a trigger later.
- R7: A scan-done strobe loads the timer with the effective interval minus `scan_dur_i`, clamped to a minimum of one tick. The effective interval is `scan_intv_i`, or the default interval parameter (10 ms of ticks) when `scan_intv_i` is zero.
- R8: Timer expiry in the off state changes nothing. Expiry in standby leaves the state unchanged and raises `err_o` for exactly one clock.
- R9: `trig_o` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Trigger source enable |
| pen_irq_i | input | 1 | Raw asynchronous pen-down interrupt level |
| scan_done_i | input | 1 | One-clock strobe when a scan has finished |
| scan_intv_i | input | TICK_W | Scan interval in clock ticks; zero selects the default |
| scan_dur_i | input | TICK_W | Scan duration in clock ticks |
| trig_o | output | 1 | One-clock scan trigger pulse |
| irq_mask_o | output | 1 | High while the pen interrupt is masked |
| state_o | output | 3 | Controller state code |
| err_o | output | 1 | One-clock pulse on timer expiry in standby |

## Verification
The hardest situation to reach is the short unmasked window that opens only after the third poll of a touch series, where a new pen edge must cancel the pending expiry and restart the count. The bench models the scan engine by answering every trigger with a done strobe a fixed number of clocks later, so the trigger grid is exactly two intervals. It then raises the pen input at a computed cycle inside that window. Expected trigger cycles are pushed into a scoreboard queue ahead of time, so a missed, early or extra trigger shows up at once. The error pulse and the ignored expiry in the off state are reached by issuing a done strobe with automatic scan answers switched off.

// File: rtl/pen_trig_pkg.sv
package pen_trig_pkg;

    // Controller state codes; values are visible on state_o.
    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_POLL      = 3'd2,
        ST_POLL_OPEN = 3'd3,
        ST_WAIT      = 3'd4
    } pen_state_e;

    // Command from the sequencer to the interval timer.
    typedef struct packed {
        logic cancel;   // drop any running count
        logic reload;   // restart with the full interval
    } tmr_cmd_t;

    // Mask level a consistent controller shows in each state.
    function automatic logic mask_for(input pen_state_e s);
        return (s == ST_OFF) || (s == ST_POLL) || (s == ST_WAIT);
    endfunction

endpackage

// File: rtl/pen_edge_sync.sv
module pen_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rise_o
);
    // STAGES flops resynchronize, one more remembers the last level.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], raw_i};
        end
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pen_interval_timer.sv
module pen_interval_timer #(
    parameter int TICK_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cancel_i,
    input  logic              load_i,
    input  logic [TICK_W-1:0] load_val_i,
    output logic              expire_o
);
    localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

    logic [TICK_W-1:0] cnt_q;
    logic              run_q;

    // Expiry is flagged during the last counted tick.
    assign expire_o = run_q && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (cancel_i) begin
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= (load_val_i == '0) ? ONE : load_val_i;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == ONE) begin
                run_q <= 1'b0;
            end
            cnt_q <= cnt_q - ONE;
        end
    end

endmodule

// File: rtl/pen_trig_fsm.sv
module pen_trig_fsm
    import pen_trig_pkg::*;
#(
    parameter int MIN_POLLS   = 3,
    parameter int EXTRA_POLLS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable_i,
    input  logic       pen_rise_i,
    input  logic       expire_i,
    output pen_state_e state_o,
    output logic       mask_o,
    output logic       trig_o,
    output logic       err_o,
    output tmr_cmd_t   tmr_cmd_o
);
    localparam int TOTAL_POLLS = MIN_POLLS + EXTRA_POLLS;
    localparam int CW          = $clog2(TOTAL_POLLS + 1);
    localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL_POLLS);
    localparam logic [CW-1:0] MIN_C   = CW'(MIN_POLLS);

    pen_state_e    st_q, st_d;
    logic          mask_q, mask_d;
    logic [CW-1:0] polls_q, polls_d;
    logic          trig_d, err_d;
    logic          en_q;
    logic          en_rise, en_fall;

    assign en_rise = enable_i & ~en_q;
    assign en_fall = ~enable_i & en_q;

    always_comb begin
        st_d      = st_q;
        mask_d    = mask_q;
        polls_d   = polls_q;
        trig_d    = 1'b0;
        err_d     = 1'b0;
        tmr_cmd_o = '0;

        if (en_fall) begin
            // shutdown wins over everything else
            st_d             = ST_OFF;
            mask_d           = 1'b1;
            polls_d          = '0;
            tmr_cmd_o.cancel = 1'b1;
        end else if (st_q == ST_OFF) begin
            if (en_rise) begin
                st_d   = ST_IDLE;
                mask_d = 1'b0;
            end
        end else if (pen_rise_i && !mask_q) begin
            // fresh touch: restart the series
            st_d             = ST_WAIT;
            mask_d           = 1'b1;
            polls_d          = '0;
            trig_d           = 1'b1;
            tmr_cmd_o.cancel = 1'b1;
        end else if (expire_i) begin
            unique case (st_q)
                ST_WAIT: begin
                    if (polls_q < TOTAL_C) begin
                        polls_d          = polls_q + 1'b1;
                        tmr_cmd_o.reload = 1'b1;
                        if ((polls_q + 1'b1) >= MIN_C) begin
                            st_d   = ST_POLL_OPEN;
                            mask_d = 1'b0;
                        end else begin
                            st_d = ST_POLL;
                        end
                    end else begin
                        st_d   = ST_IDLE;
                        mask_d = 1'b0;
                    end
                end
                ST_POLL_OPEN, ST_POLL: begin
                    st_d   = ST_WAIT;
                    mask_d = 1'b1;
                    trig_d = 1'b1;
                end
                ST_IDLE: begin
                    err_d = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            mask_q  <= 1'b1;
            polls_q <= '0;
            trig_o  <= 1'b0;
            err_o   <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            st_q    <= st_d;
            mask_q  <= mask_d;
            polls_q <= polls_d;
            trig_o  <= trig_d;
            err_o   <= err_d;
            en_q    <= enable_i;
        end
    end

    assign state_o = st_q;
    assign mask_o  = mask_q;

endmodule

// File: rtl/pen_trig_ctrl.sv
module pen_trig_ctrl
    import pen_trig_pkg::*;
#(
    parameter int TICK_W             = 24,
    parameter int DEF_INTERVAL_TICKS = 1250000,
    parameter int MIN_POLLS          = 3,
    parameter int EXTRA_POLLS        = 3,
    parameter int SYNC_STAGES        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              pen_irq_i,
    input  logic              scan_done_i,
    input  logic [TICK_W-1:0] scan_intv_i,
    input  logic [TICK_W-1:0] scan_dur_i,
    output logic              trig_o,
    output logic              irq_mask_o,
    output logic [2:0]        state_o,
    output logic              err_o
);
    localparam logic [TICK_W-1:0] DEF_C = TICK_W'(DEF_INTERVAL_TICKS);
    localparam logic [TICK_W-1:0] ONE   = TICK_W'(1);

    logic              pen_rise;
    logic              expire;
    tmr_cmd_t          cmd;
    pen_state_e        st;
    logic [TICK_W-1:0] eff_intv;
    logic [TICK_W-1:0] load_val;
    logic              load;

    pen_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pen_irq_i),
        .rise_o (pen_rise)
    );

    // Timer arming: full interval on a sequencer restart, otherwise the
    // remainder of the interval after a scan.
    always_comb begin
        eff_intv = (scan_intv_i == '0) ? DEF_C : scan_intv_i;
        load     = cmd.reload | scan_done_i;
        if (cmd.reload) begin
            load_val = eff_intv;
        end else if (eff_intv > scan_dur_i) begin
            load_val = eff_intv - scan_dur_i;
        end else begin
            load_val = ONE;
        end
    end

    pen_interval_timer #(
        .TICK_W (TICK_W)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .cancel_i   (cmd.cancel),
        .load_i     (load),
        .load_val_i (load_val),
        .expire_o   (expire)
    );

    pen_trig_fsm #(
        .MIN_POLLS   (MIN_POLLS),
        .EXTRA_POLLS (EXTRA_POLLS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable_i   (enable_i),
        .pen_rise_i (pen_rise),
        .expire_i   (expire),
        .state_o    (st),
        .mask_o     (irq_mask_o),
        .trig_o     (trig_o),
        .err_o      (err_o),
        .tmr_cmd_o  (cmd)
    );

    assign state_o = st;

endmodule

// File: rtl/pen_trig_chk.sv
module pen_trig_chk
    import pen_trig_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       enable_i,
    input logic       trig_o,
    input logic       irq_mask_o,
    input logic [2:0] state_o
);
    // R9: triggers are isolated single-clock pulses
    assert_trig_single_R9: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    // R3: a trigger coincides with the masked waiting state
    assert_trig_masked_R3: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (irq_mask_o && state_o == 3'(ST_WAIT)));

    // R2: a falling enable lands in the off state, masked
    assert_disable_off_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(enable_i) |=> (state_o == 3'(ST_OFF) && irq_mask_o));

    // R1: the mask register agrees with the state register
    assert_mask_state_R1: assert property (@(posedge clk) disable iff (rst)
        irq_mask_o == mask_for(pen_state_e'(state_o)));

    // R5: the open polling state always has the interrupt unmasked
    assert_open_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'(ST_POLL_OPEN)) |-> !irq_mask_o);

endmodule

bind pen_trig_ctrl pen_trig_chk u_pen_trig_chk (
    .clk        (clk),
    .rst        (rst),
    .enable_i   (enable_i),
    .trig_o     (trig_o),
    .irq_mask_o (irq_mask_o),
    .state_o    (state_o)
);

// File: tb/tb_pen_trig_ctrl.sv
module tb_pen_trig_ctrl;

    localparam int TW   = 16;
    localparam int DEF  = 200;
    localparam int IV   = 100;
    localparam int SD   = 5;      // scan answer delay after a trigger
    localparam int DUR  = SD + 1; // makes expiry land IV after the trigger

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable_i = 1'b0;
    logic          pen_irq_i = 1'b0;
    logic          scan_done_i = 1'b0;
    logic [TW-1:0] scan_intv_i = TW'(IV);
    logic [TW-1:0] scan_dur_i = TW'(DUR);
    logic          trig_o;
    logic          irq_mask_o;
    logic [2:0]    state_o;
    logic          err_o;

    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    int  exp_q[$];
    bit  auto_scan = 1'b1;
    bit  err_seen = 1'b0;

    pen_trig_ctrl #(
        .TICK_W             (TW),
        .DEF_INTERVAL_TICKS (DEF)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .pen_irq_i   (pen_irq_i),
        .scan_done_i (scan_done_i),
        .scan_intv_i (scan_intv_i),
        .scan_dur_i  (scan_dur_i),
        .trig_o      (trig_o),
        .irq_mask_o  (irq_mask_o),
        .state_o     (state_o),
        .err_o       (err_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic push_series(input int t0, input int n);
        for (int j = 0; j < n; j++) exp_q.push_back(t0 + 2 * IV * j);
    endtask

    // Scoreboard monitor: compares every trigger with the next expected cycle.
    always @(negedge clk) begin
        if (!rst) begin
            if (err_o) err_seen = 1'b1;
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                checks++;
                fails++;
                $display("FAIL R4 missed trigger: actual=none expected=%0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (trig_o) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected trigger: actual=%0d expected=none", cyc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        fails++;
                        $display("FAIL R4 trigger cycle: actual=%0d expected=%0d", cyc, e);
                    end
                end
            end
        end
    end

    // Scan engine model: answers each trigger with a done strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (trig_o && auto_scan) begin
                repeat (SD) @(negedge clk);
                scan_done_i = 1'b1;
                @(negedge clk);
                scan_done_i = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int k, t0, t1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 state", int'(state_o), 0);
        chk("R1 mask", int'(irq_mask_o), 1);
        chk("R1 trig", int'(trig_o), 0);
        chk("R1 err", int'(err_o), 0);

        // R3: pen edge while off does nothing
        k = cyc; pen_irq_i = 1'b1;
        wait_cyc(k + 4); pen_irq_i = 1'b0;
        wait_cyc(k + 10);
        chk("R3 off ignores pen", int'(state_o), 0);

        // R2: enable rise
        k = cyc; enable_i = 1'b1;
        wait_cyc(k + 2);
        chk("R2 standby state", int'(state_o), 1);
        chk("R2 standby unmasked", int'(irq_mask_o), 0);

        // R3/R4/R6: one touch, full series
        k = cyc; pen_irq_i = 1'b1; t0 = k + 3;
        push_series(t0, 7);
        wait_cyc(k + 4); pen_irq_i = 1'b0;
        wait_cyc(t0 + 1);
        chk("R3 wait state", int'(state_o), 4);
        chk("R3 masked", int'(irq_mask_o), 1);
        wait_cyc(t0 + 10); pen_irq_i = 1'b1;   // R6: dropped while masked
        wait_cyc(t0 + 14); pen_irq_i = 1'b0;
        wait_cyc(t0 + IV + 1);
        chk("R4 masked poll state", int'(state_o), 2);
        wait_cyc(t0 + 5 * IV + 1);
        chk("R5 open poll state", int'(state_o), 3);
        chk("R5 open unmasked", int'(irq_mask_o), 0);
        wait_cyc(t0 + 13 * IV + 1);
        chk("R4 back to standby", int'(state_o), 1);
        chk("R4 standby unmasked", int'(irq_mask_o), 0);
        wait_cyc(t0 + 13 * IV + 5);
        chk("R4 all triggers seen", exp_q.size(), 0);

        // R5: retrigger inside the open window restarts the series
        k = cyc; pen_irq_i = 1'b1; t0 = k + 3;
        push_series(t0, 3);
        wait_cyc(k + 4); pen_irq_i = 1'b0;
        wait_cyc(t0 + 5 * IV + 10);
        chk("R5 in open window", int'(state_o), 3);
        k = cyc; pen_irq_i = 1'b1; t1 = k + 3;
        push_series(t1, 2);
        wait_cyc(k + 4); pen_irq_i = 1'b0;
        wait_cyc(t1 + 1);
        chk("R5 restarted wait", int'(state_o), 4);

        // R2: disable mid-series stops everything
        wait_cyc(t1 + 3 * IV);
        k = cyc; enable_i = 1'b0;
        wait_cyc(k + 2);
        chk("R2 off state", int'(state_o), 0);
        chk("R2 off masked", int'(irq_mask_o), 1);
        wait_cyc(k + 4 * IV);
        chk("R2 no triggers after disable", exp_q.size(), 0);

        // R8: expiry while off is ignored
        auto_scan = 1'b0; err_seen = 1'b0;
        k = cyc; scan_done_i = 1'b1;
        wait_cyc(k + 1); scan_done_i = 1'b0;
        wait_cyc(k + IV + 10);
        chk("R8 off expiry state", int'(state_o), 0);
        chk("R8 off expiry no error", int'(err_seen), 0);

        // R8: expiry in standby raises one-cycle error
        k = cyc; enable_i = 1'b1;
        wait_cyc(k + 3);
        k = cyc; scan_done_i = 1'b1;
        wait_cyc(k + 1); scan_done_i = 1'b0;
        wait_cyc(k + 1 + (IV - DUR));
        chk("R8 error pulse", int'(err_o), 1);
        chk("R8 state kept", int'(state_o), 1);
        wait_cyc(k + 2 + (IV - DUR));
        chk("R8 error one cycle", int'(err_o), 0);

        // R7: zero interval selects the default
        auto_scan = 1'b1; scan_intv_i = '0;
        k = cyc; pen_irq_i = 1'b1; t0 = k + 3;
        exp_q.push_back(t0);
        exp_q.push_back(t0 + 2 * DEF);
        wait_cyc(k + 4); pen_irq_i = 1'b0;
        wait_cyc(t0 + 2 * DEF + 50); enable_i = 1'b0;
        wait_cyc(t0 + 5 * DEF);
        chk("R7 default interval", exp_q.size(), 0);

        // R7: duration above interval clamps the wait to one tick
        scan_intv_i = TW'(20); scan_dur_i = TW'(50);
        k = cyc; enable_i = 1'b1;
        wait_cyc(k + 3);
        k = cyc; pen_irq_i = 1'b1; t0 = k + 3;
        exp_q.push_back(t0);
        exp_q.push_back(t0 + 27);
        wait_cyc(k + 4); pen_irq_i = 1'b0;
        wait_cyc(t0 + 30); enable_i = 1'b0;
        wait_cyc(t0 + 100);
        chk("R7 clamped wait", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule